// File: doc/BRIEF.md
# SPI Receive Enable Controller

This block is the control state machine that governs when a serial peripheral interface receiver accepts a character. It works as bus master or as slave. As slave it runs in either a three-wire form, which has no select pin, or a four-wire form, where an active-low select input gates reception. It serializes one character into a holding register and raises a receive-complete flag that stays set until software clears it. If a character completes while that flag is still set, it raises an overrun flag. Its state code is brought out so that the surrounding logic and software can observe it.

Four things end reception: a power-up clear, a software reset, or clearing the module enable. In four-wire slave mode, the select input going inactive also ends it. The start condition depends on the mode. A master starts when the transmit buffer is written. A slave starts at the first serial clock rising edge. Re-enabling does not realign to character boundaries, so the software protocol must keep the link framed. The serial inputs are asynchronous and are synchronized inside the block.

Top module: `spi_rx_ctrl`

## Requirements
- R1: While `pwr_clr_n` is low, `state_o` is 0, and `rx_done`, `overrun` and `rx_data` are 0. The state codes are 0 = off, 1 = idle (receiver armed), 2 = collecting, 3 = interrupt handling.
- R2: A high `soft_rst` puts the machine in state 0 at the next clock from any state and clears `rx_done` and `overrun`. Any partial character is discarded, so the next character is received whole.
- R3: With `mod_en` low the machine goes to state 0 at the next clock and discards any partial character. Serial clock edges have no effect while it is off. With `mod_en` high and `soft_rst` low, state 0 moves to state 1 at the next clock.
- R4: With `is_master` = 1, state 1 moves to state 2 only on a `txbuf_wr` pulse. Serial clock edges in state 1 leave the state at 1 and set no flag.
- R5: With `is_master` = 0, state 1 moves to state 2 on a rising serial clock edge, and that edge samples the first bit. In four-wire mode (`four_pin` = 1) such an edge starts reception only while `ss_n` is low.
- R6: A character is 8 bits, taken most significant bit first on rising `sclk` edges. After the eighth bit, `rx_data` holds the character and `rx_done` is 1. The state is 3 for exactly one clock and then 1.
- R7: In three-wire slave mode (`four_pin` = 0), `ss_n` has no effect on reception.
- R8: In four-wire slave mode, `ss_n` high while in state 2 returns the machine to state 1 and clears the bit count, so the next framed character is received whole and no flag is set for the aborted one.
- R9: `rx_done` stays 1 until a one-cycle `flag_clr` pulse, which clears both `rx_done` and `overrun` at the next clock.
- R10: When a character completes while `rx_done` is still 1, `overrun` becomes 1 and `rx_data` takes the new character.
- R11: `sclk`, `sdi` and `ss_n` pass through two-stage synchronizers. When `sclk` rises between clock edges, `rx_done` for the final bit becomes 1 at the third rising clock edge after that change and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_clr_n | input | 1 | Power-up clear, asynchronous, active low |
| soft_rst | input | 1 | Software reset, synchronous, active high |
| mod_en | input | 1 | Module receive/transmit enable |
| is_master | input | 1 | 1 = master, 0 = slave |
| four_pin | input | 1 | Slave mode: 1 = four-wire with select, 0 = three-wire |
| txbuf_wr | input | 1 | Transmit-buffer write strobe (master start) |
| flag_clr | input | 1 | Clears receive-complete and overrun flags |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| ss_n | input | 1 | Slave select, active low, asynchronous |
| rx_data | output | 8 | Last received character |
| rx_done | output | 1 | Receive-complete interrupt flag |
| overrun | output | 1 | Character completed while flag still set |
| state_o | output | 2 | Controller state code |

## Verification
A wrong state register shows at `state_o` within one clock of the transition that was missed: a missed start leaves the code at 1, and a missed abort leaves it at 2. A wrong bit count or a shift-order error appears as a corrupted `rx_data` value or a misplaced `rx_done` rise within three clocks of the last serial edge of a character. Every byte value is swept in slave mode, and subsets are swept in master and four-wire modes, so each data bit position and each start path is exercised.

// File: rtl/spi_rx_pkg.sv
`timescale 1ns/1ps
package spi_rx_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_GRAB = 2'd2,
        ST_IRQ  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/spi_rx_sync.sv
`timescale 1ns/1ps
// Multi-bit, per-bit independent synchronizer chain.
module spi_rx_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        end
        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_rx_shift.sv
`timescale 1ns/1ps
// Character shifter with bit counter, MSB first.
module spi_rx_shift #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] word_nxt_o,
    output logic              last_o
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (shift_i) begin
            shf_d.sh  = {shf_q.sh[DATA_W-2:0], bit_i};
            shf_d.cnt = (shf_q.cnt == CNT_W'(DATA_W-1)) ? '0 : shf_q.cnt + 1'b1;
        end else if (clr_i) begin
            shf_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign word_nxt_o = {shf_q.sh[DATA_W-2:0], bit_i};
    assign last_o     = (shf_q.cnt == CNT_W'(DATA_W-1));
endmodule

// File: rtl/spi_rx_ctrl.sv
`timescale 1ns/1ps
// Receive enable controller: master / three-wire slave / four-wire slave.
module spi_rx_ctrl #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              pwr_clr_n,
    input  logic              soft_rst,
    input  logic              mod_en,
    input  logic              is_master,
    input  logic              four_pin,
    input  logic              txbuf_wr,
    input  logic              flag_clr,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              ss_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done,
    output logic              overrun,
    output logic [1:0]        state_o
);
    import spi_rx_pkg::*;

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        rx_state_e         state;
        logic              sclk_prev;
        logic [DATA_W-1:0] rx_data;
        logic              rx_done;
        logic              overrun;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [2:0]        syn;
    logic              sclk_s, sdi_s, ss_s;
    logic              shift_en, shift_clr, last_bit;
    logic [DATA_W-1:0] word_nxt;
    logic              rise, run, halt4, slave_go;

    spi_rx_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) i_sync (
        .clk    (clk),
        .rst_n  (pwr_clr_n),
        .async_i({ss_n, sdi, sclk}),
        .sync_o (syn)
    );

    assign sclk_s = syn[0];
    assign sdi_s  = syn[1];
    assign ss_s   = syn[2];

    spi_rx_shift #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) i_shift (
        .clk       (clk),
        .rst_n     (pwr_clr_n),
        .clr_i     (shift_clr),
        .shift_i   (shift_en),
        .bit_i     (sdi_s),
        .word_nxt_o(word_nxt),
        .last_o    (last_bit)
    );

    always_comb begin
        ctl_d           = ctl_q;
        shift_en        = 1'b0;
        rise            = sclk_s & ~ctl_q.sclk_prev;
        run             = mod_en & ~soft_rst;
        halt4           = ~is_master & four_pin & ss_s;
        slave_go        = ~is_master & (~four_pin | ~ss_s) & rise;
        ctl_d.sclk_prev = sclk_s;

        if (flag_clr || soft_rst) begin
            ctl_d.rx_done = 1'b0;
            ctl_d.overrun = 1'b0;
        end

        if (!run) begin
            ctl_d.state = ST_OFF;
        end else begin
            case (ctl_q.state)
                ST_OFF: ctl_d.state = ST_IDLE;
                ST_IDLE: begin
                    if (is_master) begin
                        if (txbuf_wr) ctl_d.state = ST_GRAB;
                    end else if (slave_go) begin
                        shift_en    = 1'b1;
                        ctl_d.state = ST_GRAB;
                    end
                end
                ST_GRAB: begin
                    if (halt4) begin
                        ctl_d.state = ST_IDLE;
                    end else if (rise) begin
                        shift_en = 1'b1;
                        if (last_bit) begin
                            ctl_d.state   = ST_IRQ;
                            ctl_d.rx_data = word_nxt;
                            ctl_d.overrun = ctl_d.overrun | (ctl_q.rx_done & ~flag_clr);
                            ctl_d.rx_done = 1'b1;
                        end
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end

        shift_clr = (ctl_d.state != ST_GRAB);
    end

    always_ff @(posedge clk or negedge pwr_clr_n) begin
        if (!pwr_clr_n) begin
            ctl_q <= '{state: ST_OFF, sclk_prev: 1'b0, rx_data: '0,
                       rx_done: 1'b0, overrun: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rx_data = ctl_q.rx_data;
    assign rx_done = ctl_q.rx_done;
    assign overrun = ctl_q.overrun;
    assign state_o = ctl_q.state;
endmodule

// File: rtl/spi_rx_ctrl_chk.sv
`timescale 1ns/1ps
module spi_rx_ctrl_chk (
    input logic       clk,
    input logic       pwr_clr_n,
    input logic       soft_rst,
    input logic       mod_en,
    input logic       is_master,
    input logic       four_pin,
    input logic       txbuf_wr,
    input logic       ss_s,
    input logic [1:0] state_o,
    input logic       rx_done,
    input logic       overrun
);
    // R2
    sw_rst_chk: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        soft_rst |=> (state_o == 2'd0 && !rx_done && !overrun));

    // R3
    en_off_chk: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        !mod_en |=> state_o == 2'd0);

    // R3
    wake_chk: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        (state_o == 2'd0 && mod_en && !soft_rst) |=> state_o == 2'd1);

    // R4
    master_hold_chk: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        (state_o == 2'd1 && is_master && !txbuf_wr && mod_en && !soft_rst)
        |=> state_o == 2'd1);

    // R8
    halt4_chk: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        (state_o == 2'd2 && !is_master && four_pin && ss_s && mod_en && !soft_rst)
        |=> state_o == 2'd1);

    // R6
    irq_ret_chk: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        (state_o == 2'd3 && mod_en && !soft_rst) |=> state_o == 2'd1);

    // R6
    done_chk: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        $rose(rx_done) |-> state_o == 2'd3);

    // R10
    ovr_chk: assert property (@(posedge clk) disable iff (!pwr_clr_n)
        $rose(overrun) |-> $past(rx_done));
endmodule

bind spi_rx_ctrl spi_rx_ctrl_chk i_chk (
    .clk      (clk),
    .pwr_clr_n(pwr_clr_n),
    .soft_rst (soft_rst),
    .mod_en   (mod_en),
    .is_master(is_master),
    .four_pin (four_pin),
    .txbuf_wr (txbuf_wr),
    .ss_s     (ss_s),
    .state_o  (state_o),
    .rx_done  (rx_done),
    .overrun  (overrun)
);

// File: tb/test_spi_rx_ctrl.sv
`timescale 1ns/1ps
module test_spi_rx_ctrl;
    logic       clk = 1'b0;
    logic       pwr_clr_n, soft_rst, mod_en, is_master, four_pin;
    logic       txbuf_wr, flag_clr, sclk, sdi, ss_n;
    logic [7:0] rx_data;
    logic       rx_done, overrun;
    logic [1:0] state_o;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    spi_rx_ctrl i_spi_rx_ctrl (
        .clk(clk), .pwr_clr_n(pwr_clr_n), .soft_rst(soft_rst), .mod_en(mod_en),
        .is_master(is_master), .four_pin(four_pin), .txbuf_wr(txbuf_wr),
        .flag_clr(flag_clr), .sclk(sclk), .sdi(sdi), .ss_n(ss_n),
        .rx_data(rx_data), .rx_done(rx_done), .overrun(overrun), .state_o(state_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        sdi = b; tick(3);
        sclk = 1'b1; tick(4);
        sclk = 1'b0; tick(3);
    endtask

    task automatic send_bits(input logic [7:0] d, input int n);
        for (int i = 7; i > 7 - n; i--) sbit(d[i]);
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    endtask

    task automatic expect_char(input string req, input logic [7:0] v, input logic ovr);
        tick(2);
        chk({req, " data"}, int'(rx_data), int'(v));
        chk({req, " done"}, int'(rx_done), 1);
        chk({req, " ovr"}, int'(overrun), int'(ovr));
        chk({req, " state"}, int'(state_o), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pwr_clr_n = 1'b0; soft_rst = 1'b0; mod_en = 1'b0; is_master = 1'b0;
        four_pin = 1'b0; txbuf_wr = 1'b0; flag_clr = 1'b0; sclk = 1'b0;
        sdi = 1'b0; ss_n = 1'b1;
        tick(3);
        // R1
        chk("R1 state", int'(state_o), 0);
        chk("R1 done", int'(rx_done), 0);
        chk("R1 ovr", int'(overrun), 0);
        chk("R1 data", int'(rx_data), 0);
        pwr_clr_n = 1'b1; tick(2);
        chk("R3 off while disabled", int'(state_o), 0);
        mod_en = 1'b1; tick(1);
        chk("R3 wake", int'(state_o), 1);

        // R11 / R6: latency of completion, one-cycle interrupt state
        send_bits(8'hA5, 7);
        sdi = 1'b1; tick(3);
        sclk = 1'b1; tick(2);
        chk("R11 not yet", int'(rx_done), 0);
        tick(1);
        chk("R11 done edge3", int'(rx_done), 1);
        chk("R6 irq state", int'(state_o), 3);
        tick(1);
        chk("R6 back idle", int'(state_o), 1);
        chk("R6 data A5", int'(rx_data), 8'hA5);
        sclk = 1'b0; tick(3);
        clear_flags();

        // R6 / R5: all byte values, three-wire slave
        for (int v = 0; v < 256; v++) begin
            send_bits(8'(v), 8);
            expect_char("R6 sweep", 8'(v), 1'b0);
            clear_flags();
        end

        // R7: select toggling ignored in three-wire mode
        send_bits(8'h3C, 4);
        ss_n = 1'b0; tick(3); ss_n = 1'b1; tick(3);
        chk("R7 still collecting", int'(state_o), 2);
        for (int i = 3; i >= 0; i--) sbit(1'(8'h3C >> i));
        expect_char("R7", 8'h3C, 1'b0);
        clear_flags();

        // R9 / R10
        send_bits(8'h11, 8);
        tick(20);
        chk("R9 holds", int'(rx_done), 1);
        send_bits(8'h22, 8);
        expect_char("R10", 8'h22, 1'b1);
        clear_flags();
        chk("R9 done cleared", int'(rx_done), 0);
        chk("R9 ovr cleared", int'(overrun), 0);

        // R2: software reset mid-character
        send_bits(8'h55, 8); tick(2);
        send_bits(8'hF0, 4);
        soft_rst = 1'b1; tick(1);
        chk("R2 off", int'(state_o), 0);
        chk("R2 done clr", int'(rx_done), 0);
        soft_rst = 1'b0; tick(1);
        chk("R2 idle", int'(state_o), 1);
        send_bits(8'h96, 8);
        expect_char("R2 whole", 8'h96, 1'b0);
        clear_flags();

        // R3: disable mid-character, edges ignored while off
        send_bits(8'hE7, 3);
        mod_en = 1'b0; tick(1);
        chk("R3 off", int'(state_o), 0);
        sbit(1'b1); sbit(1'b0);
        chk("R3 off edges", int'(state_o), 0);
        chk("R3 no flag", int'(rx_done), 0);
        mod_en = 1'b1; tick(1);
        chk("R3 re-idle", int'(state_o), 1);
        send_bits(8'h69, 8);
        expect_char("R3 whole", 8'h69, 1'b0);
        clear_flags();

        // R4: master mode
        is_master = 1'b1;
        sbit(1'b1); sbit(1'b1); sbit(1'b0);
        chk("R4 idle ignores sclk", int'(state_o), 1);
        chk("R4 no flag", int'(rx_done), 0);
        for (int i = 0; i < 32; i++) begin
            txbuf_wr = 1'b1; tick(1); txbuf_wr = 1'b0;
            chk("R4 start", int'(state_o), 2);
            send_bits(8'(i * 8 + 3), 8);
            expect_char("R4 sweep", 8'(i * 8 + 3), 1'b0);
            clear_flags();
        end

        // R5 / R8: four-wire slave
        is_master = 1'b0; four_pin = 1'b1; ss_n = 1'b1;
        sbit(1'b1); sbit(1'b0);
        chk("R5 gated by select", int'(state_o), 1);
        ss_n = 1'b0; tick(3);
        for (int i = 0; i < 32; i++) begin
            send_bits(8'(255 - i * 7), 8);
            expect_char("R5 sweep", 8'(255 - i * 7), 1'b0);
            clear_flags();
        end
        send_bits(8'hC3, 5);
        ss_n = 1'b1; tick(4);
        chk("R8 halted", int'(state_o), 1);
        chk("R8 no flag", int'(rx_done), 0);
        ss_n = 1'b0; tick(3);
        send_bits(8'h5A, 8);
        expect_char("R8 whole", 8'h5A, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule